// File: doc/BRIEF.md
# Masked Path-Table Fallback Lookup

This block sits beside an associative match array and gives a second opinion on every compare. It holds a 4096-entry, one-bit flag table indexed by the top 12 bits of the 32-bit comparand, the field that carries the virtual path identifier of a cell header. A configurable mask can force chosen index bits to zero before the table is read, so a group of paths can share one entry. Each compare merges the table's answer with the match array's own result. A match-array hit always wins. A table hit only counts when the match array missed and the table is switched on.

The block produces two active-low flags. One says "something matched", the other says "the match array matched". It also gives the winning address and page. The table is never cleared by reset. Software must write every entry through the single-cycle write port before it sets the enable bit.

Top module: `pathtbl_fallback`

## Requirements
- R1: The table has 4096 one-bit entries. A write with `wrEn` high stores `wrData` at `wrIdx` in one cycle and is visible to every compare issued in a later cycle. A compare issued in the same cycle as a write to the same index sees the old value.
- R2: A stored 0 means hit and a stored 1 means miss.
- R3: The table index is `comparand[31:20] & ~cfgWord[23:12]`. A 1 in `cfgWord[12+k]` forces index bit k (comparand bit 20+k) to zero.
- R4: The table takes part only when `cfgWord[24]` is 1. With it at 0, a compare without a match-array hit reports a miss whatever the table holds.
- R5: When `camMatch` is 1 on a compare, `resultAddr` is `camAddr` and `resultPage` is `camPage`, whatever the table holds.
- R6: `matchValidN` is 0 when there is a match-array hit or a table hit. `matchFoundN` is 0 only on a match-array hit.
- R7: On a table hit with no match-array hit, `resultAddr` is the masked index and `resultPage` is `tblPage`.
- R8: Results of a compare appear one cycle after the compare cycle and hold, unchanged by inputs or table writes, until the next compare.
- R9: During and after reset, both flags are 1 and `resultAddr`/`resultPage` are 0. Reset does not alter table contents.
- R10: A compare with neither hit sets both flags to 1 and drives 0 on `resultAddr` and `resultPage`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmpValid | input | 1 | Compare cycle strobe |
| comparand | input | 32 | Compare word; bits 31..20 index the table |
| camMatch | input | 1 | Match-array hit for this compare |
| camAddr | input | 12 | Match-array hit address |
| camPage | input | 4 | Page reported with a match-array hit |
| tblPage | input | 4 | Page reported with a table hit |
| cfgWord | input | 32 | Configuration: bit 24 table enable, bits 23..12 index mask |
| wrEn | input | 1 | Table write strobe |
| wrIdx | input | 12 | Table write index |
| wrData | input | 1 | Table write bit (0 = hit) |
| matchValidN | output | 1 | Active-low any-match flag |
| matchFoundN | output | 1 | Active-low match-array-match flag |
| resultAddr | output | 12 | Winning address |
| resultPage | output | 4 | Winning page |

## Verification
Each compare is sampled at one rising edge. All four results are due at that same edge: one register stage covers both the table read and the merged outputs. The bench drives a compare on a falling edge and reads the outputs on the next falling edge, half a cycle after they settle. For the hold and same-cycle write cases, the bench keeps sampling over further falling edges. This confirms that nothing moves until the next compare and that a write becomes visible only to the compare after it.

// File: rtl/pathtbl_pkg.sv
package pathtbl_pkg;
  typedef struct packed {
    logic lookup;   // compare cycle in progress
    logic tableOn;  // table participates in this compare
    logic write;    // table write this cycle
  } pathtblStrobe_t;
endpackage

// File: rtl/pathtbl_ctrl.sv
module pathtbl_ctrl
  import pathtbl_pkg::*;
#(
  parameter int CFG_W      = 32,
  parameter int CFG_EN_BIT = 24
) (
  input  logic             cmpValid,
  input  logic             wrEn,
  input  logic [CFG_W-1:0] cfgWord,
  output pathtblStrobe_t   strobe
);
  always_comb begin
    strobe.lookup  = cmpValid;
    strobe.tableOn = cmpValid & cfgWord[CFG_EN_BIT];
    strobe.write   = wrEn;
  end
endmodule

// File: rtl/pathtbl_datapath.sv
module pathtbl_datapath
  import pathtbl_pkg::*;
#(
  parameter int IDX_W  = 12,
  parameter int ADDR_W = 12,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  pathtblStrobe_t    strobe,
  input  logic [IDX_W-1:0]  rawIdx,
  input  logic [IDX_W-1:0]  idxMask,
  input  logic              camMatch,
  input  logic [ADDR_W-1:0] camAddr,
  input  logic [PAGE_W-1:0] camPage,
  input  logic [PAGE_W-1:0] tblPage,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic              wrData,
  output logic              matchValidN,
  output logic              matchFoundN,
  output logic [ADDR_W-1:0] resultAddr,
  output logic [PAGE_W-1:0] resultPage
);
  localparam int DEPTH = 1 << IDX_W;

  logic              flagMem [DEPTH];
  logic [IDX_W-1:0]  maskedIdx;
  logic              tblBitQ;
  logic              camHitQ;
  logic              tblOnQ;
  logic [ADDR_W-1:0] camAddrQ;
  logic [PAGE_W-1:0] camPageQ;
  logic [IDX_W-1:0]  idxQ;
  logic [PAGE_W-1:0] tblPageQ;
  logic              tblHit;

  assign maskedIdx = rawIdx & ~idxMask;

  // Table storage: no reset, read-before-write on a shared index.
  always_ff @(posedge clk) begin
    if (strobe.write) flagMem[wrIdx] <= wrData;
    if (strobe.lookup) tblBitQ <= flagMem[maskedIdx];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      camHitQ  <= 1'b0;
      tblOnQ   <= 1'b0;
      camAddrQ <= '0;
      camPageQ <= '0;
      idxQ     <= '0;
      tblPageQ <= '0;
    end else if (strobe.lookup) begin
      camHitQ  <= camMatch;
      tblOnQ   <= strobe.tableOn;
      camAddrQ <= camAddr;
      camPageQ <= camPage;
      idxQ     <= maskedIdx;
      tblPageQ <= tblPage;
    end
  end

  assign tblHit = tblOnQ & ~tblBitQ;

  always_comb begin
    matchFoundN = ~camHitQ;
    matchValidN = ~(camHitQ | tblHit);
    if (camHitQ) begin
      resultAddr = camAddrQ;
      resultPage = camPageQ;
    end else if (tblHit) begin
      resultAddr = ADDR_W'(idxQ);
      resultPage = tblPageQ;
    end else begin
      resultAddr = '0;
      resultPage = '0;
    end
  end
endmodule

// File: rtl/pathtbl_fallback.sv
module pathtbl_fallback
  import pathtbl_pkg::*;
#(
  parameter int CMP_W        = 32,
  parameter int CFG_W        = 32,
  parameter int IDX_W        = 12,
  parameter int ADDR_W       = 12,
  parameter int PAGE_W       = 4,
  parameter int CFG_EN_BIT   = 24,
  parameter int CFG_MASK_LSB = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmpValid,
  input  logic [CMP_W-1:0]  comparand,
  input  logic              camMatch,
  input  logic [ADDR_W-1:0] camAddr,
  input  logic [PAGE_W-1:0] camPage,
  input  logic [PAGE_W-1:0] tblPage,
  input  logic [CFG_W-1:0]  cfgWord,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic              wrData,
  output logic              matchValidN,
  output logic              matchFoundN,
  output logic [ADDR_W-1:0] resultAddr,
  output logic [PAGE_W-1:0] resultPage
);
  localparam int IDX_LSB = CMP_W - IDX_W;

  pathtblStrobe_t strobe;

  pathtbl_ctrl #(.CFG_W(CFG_W), .CFG_EN_BIT(CFG_EN_BIT)) uCtrl (
    .cmpValid(cmpValid),
    .wrEn    (wrEn),
    .cfgWord (cfgWord),
    .strobe  (strobe)
  );

  pathtbl_datapath #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .rawIdx     (comparand[CMP_W-1:IDX_LSB]),
    .idxMask    (cfgWord[CFG_MASK_LSB+IDX_W-1:CFG_MASK_LSB]),
    .camMatch   (camMatch),
    .camAddr    (camAddr),
    .camPage    (camPage),
    .tblPage    (tblPage),
    .wrIdx      (wrIdx),
    .wrData     (wrData),
    .matchValidN(matchValidN),
    .matchFoundN(matchFoundN),
    .resultAddr (resultAddr),
    .resultPage (resultPage)
  );
endmodule

// File: rtl/pathtbl_checker.sv
module pathtbl_checker #(
  parameter int CMP_W        = 32,
  parameter int CFG_W        = 32,
  parameter int IDX_W        = 12,
  parameter int ADDR_W       = 12,
  parameter int PAGE_W       = 4,
  parameter int CFG_EN_BIT   = 24,
  parameter int CFG_MASK_LSB = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmpValid,
  input logic [CMP_W-1:0]  comparand,
  input logic              camMatch,
  input logic [ADDR_W-1:0] camAddr,
  input logic [PAGE_W-1:0] camPage,
  input logic [PAGE_W-1:0] tblPage,
  input logic [CFG_W-1:0]  cfgWord,
  input logic              matchValidN,
  input logic              matchFoundN,
  input logic [ADDR_W-1:0] resultAddr,
  input logic [PAGE_W-1:0] resultPage
);
  localparam int IDX_LSB = CMP_W - IDX_W;

  logic [IDX_W-1:0] expIdx;
  assign expIdx = comparand[CMP_W-1:IDX_LSB] & ~cfgWord[CFG_MASK_LSB+IDX_W-1:CFG_MASK_LSB];

  assert_found_implies_valid_R6: assert property (@(posedge clk) disable iff (!rstN)
    !matchFoundN |-> !matchValidN);

  assert_no_cam_no_found_R6: assert property (@(posedge clk) disable iff (!rstN)
    cmpValid && !camMatch |=> matchFoundN);

  assert_cam_priority_R5: assert property (@(posedge clk) disable iff (!rstN)
    cmpValid && camMatch |=> !matchFoundN && resultAddr == $past(camAddr)
                             && resultPage == $past(camPage));

  assert_disabled_ignored_R4: assert property (@(posedge clk) disable iff (!rstN)
    cmpValid && !camMatch && !cfgWord[CFG_EN_BIT] |=>
      matchValidN && resultAddr == '0 && resultPage == '0);

  assert_table_hit_result_R7: assert property (@(posedge clk) disable iff (!rstN)
    cmpValid && !camMatch |=> matchValidN ||
      (resultAddr == ADDR_W'($past(expIdx)) && resultPage == $past(tblPage)));

  assert_hold_between_compares_R8: assert property (@(posedge clk) disable iff (!rstN)
    !cmpValid |=> $stable(matchValidN) && $stable(matchFoundN)
                  && $stable(resultAddr) && $stable(resultPage));
endmodule

bind pathtbl_fallback pathtbl_checker #(
  .CMP_W(CMP_W), .CFG_W(CFG_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .PAGE_W(PAGE_W),
  .CFG_EN_BIT(CFG_EN_BIT), .CFG_MASK_LSB(CFG_MASK_LSB)
) uChk (
  .clk(clk), .rstN(rstN), .cmpValid(cmpValid), .comparand(comparand),
  .camMatch(camMatch), .camAddr(camAddr), .camPage(camPage), .tblPage(tblPage),
  .cfgWord(cfgWord), .matchValidN(matchValidN), .matchFoundN(matchFoundN),
  .resultAddr(resultAddr), .resultPage(resultPage)
);

// File: tb/tb_pathtbl_fallback.sv
module tb_pathtbl_fallback;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmpValid = 1'b0;
  logic [31:0] comparand = '0;
  logic        camMatch = 1'b0;
  logic [11:0] camAddr = '0;
  logic [3:0]  camPage = '0;
  logic [3:0]  tblPage = '0;
  logic [31:0] cfgWord = '0;
  logic        wrEn = 1'b0;
  logic [11:0] wrIdx = '0;
  logic        wrData = 1'b0;
  logic        matchValidN, matchFoundN;
  logic [11:0] resultAddr;
  logic [3:0]  resultPage;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pathtbl_fallback dut (
    .clk(clk), .rstN(rstN), .cmpValid(cmpValid), .comparand(comparand),
    .camMatch(camMatch), .camAddr(camAddr), .camPage(camPage), .tblPage(tblPage),
    .cfgWord(cfgWord), .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
    .matchValidN(matchValidN), .matchFoundN(matchFoundN),
    .resultAddr(resultAddr), .resultPage(resultPage)
  );

  function automatic logic [31:0] mkCfg(input logic en, input logic [11:0] mask);
    return {7'd0, en, mask, 12'h5A5};
  endfunction

  task automatic checkOut(input logic eV, input logic eF, input logic [11:0] eA,
                          input logic [3:0] eP, input string tag);
    testsRun++;
    if (matchValidN !== eV || matchFoundN !== eF || resultAddr !== eA || resultPage !== eP) begin
      testsFailed++;
      $display("FAIL %s: got V=%b F=%b A=%h P=%h, expected V=%b F=%b A=%h P=%h",
               tag, matchValidN, matchFoundN, resultAddr, resultPage, eV, eF, eA, eP);
    end
  endtask

  task automatic doWrite(input logic [11:0] idx, input logic d);
    @(negedge clk);
    wrEn = 1'b1; wrIdx = idx; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // Drives one compare; returns at the falling edge after the sampling edge.
  task automatic doCompare(input logic [11:0] idx, input logic cm, input logic [11:0] ca,
                           input logic [3:0] cp, input logic [3:0] tp,
                           input logic en, input logic [11:0] mask);
    @(negedge clk);
    cmpValid = 1'b1; comparand = {idx, 20'hC3E71};
    camMatch = cm; camAddr = ca; camPage = cp; tblPage = tp; cfgWord = mkCfg(en, mask);
    @(negedge clk);
    cmpValid = 1'b0;
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    checkOut(1, 1, 12'h0, 4'h0, "R9 outputs during reset");
    rstN = 1'b1;
    @(negedge clk);
    checkOut(1, 1, 12'h0, 4'h0, "R9 outputs after reset");
  endtask

  task automatic fillTable();
    @(negedge clk);
    for (int i = 0; i < 4096; i++) begin
      wrEn = 1'b1; wrIdx = 12'(i); wrData = 1'b1;
      @(negedge clk);
    end
    wrEn = 1'b0;
  endtask

  task automatic testMiss();
    doCompare(12'h300, 0, 12'h111, 4'h2, 4'h9, 1, 12'h000);
    checkOut(1, 1, 12'h0, 4'h0, "R10 miss on both");
  endtask

  task automatic testTableHit();
    doWrite(12'h155, 1'b0);
    doCompare(12'h155, 0, 12'h222, 4'h1, 4'hA, 1, 12'h000);
    checkOut(0, 1, 12'h155, 4'hA, "R2 R7 table hit");
  endtask

  task automatic testCamPriority();
    doCompare(12'h155, 1, 12'h7E1, 4'h3, 4'hA, 1, 12'h000);
    checkOut(0, 0, 12'h7E1, 4'h3, "R5 cam wins over table hit");
    doCompare(12'h300, 1, 12'h042, 4'h6, 4'hA, 0, 12'h000);
    checkOut(0, 0, 12'h042, 4'h6, "R5 R6 cam hit, table off");
  endtask

  task automatic testDisabled();
    doCompare(12'h155, 0, 12'h222, 4'h1, 4'hA, 0, 12'h000);
    checkOut(1, 1, 12'h0, 4'h0, "R4 table disabled ignores hit");
  endtask

  task automatic testMask();
    doWrite(12'h0A0, 1'b0);
    doCompare(12'h0AF, 0, 12'h0, 4'h0, 4'h5, 1, 12'h000);
    checkOut(1, 1, 12'h0, 4'h0, "R3 unmasked index misses");
    doCompare(12'h0AF, 0, 12'h0, 4'h0, 4'h5, 1, 12'h00F);
    checkOut(0, 1, 12'h0A0, 4'h5, "R3 low mask bits forced to zero");
    doCompare(12'h8A0, 0, 12'h0, 4'h0, 4'hC, 1, 12'h800);
    checkOut(0, 1, 12'h0A0, 4'hC, "R3 top mask bit forced to zero");
  endtask

  task automatic testHold();
    doCompare(12'h155, 0, 12'h0, 4'h0, 4'h7, 1, 12'h000);
    checkOut(0, 1, 12'h155, 4'h7, "R8 result one cycle after compare");
    @(negedge clk);
    comparand = 32'hFFFFFFFF; camMatch = 1'b1; camAddr = 12'hABC; tblPage = 4'h1;
    wrEn = 1'b1; wrIdx = 12'h155; wrData = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    repeat (2) @(negedge clk);
    checkOut(0, 1, 12'h155, 4'h7, "R8 held with no compare");
    doCompare(12'h155, 0, 12'h0, 4'h0, 4'h7, 1, 12'h000);
    checkOut(1, 1, 12'h0, 4'h0, "R1 later compare sees write");
  endtask

  task automatic testSameCycle();
    @(negedge clk);
    wrEn = 1'b1; wrIdx = 12'h050; wrData = 1'b0;
    cmpValid = 1'b1; comparand = {12'h050, 20'h0}; camMatch = 1'b0;
    tblPage = 4'hE; cfgWord = mkCfg(1, 12'h000);
    @(negedge clk);
    wrEn = 1'b0; cmpValid = 1'b0;
    checkOut(1, 1, 12'h0, 4'h0, "R1 same-cycle compare sees old value");
    doCompare(12'h050, 0, 12'h0, 4'h0, 4'hE, 1, 12'h000);
    checkOut(0, 1, 12'h050, 4'hE, "R1 next compare sees new value");
  endtask

  task automatic testResetKeepsTable();
    doWrite(12'h123, 1'b0);
    testReset();
    doCompare(12'h123, 0, 12'h0, 4'h0, 4'hB, 1, 12'h000);
    checkOut(0, 1, 12'h123, 4'hB, "R9 table survives reset");
  endtask

  initial begin
    testReset();
    fillTable();
    testMiss();
    testTableHit();
    testCamPriority();
    testDisabled();
    testMask();
    testHold();
    testSameCycle();
    testResetKeepsTable();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule